// File: doc/BRIEF.md
# Multiply-Divide Unit with HI/LO Result Pair

This block is the integer multiply and divide engine of a small load-store processor. It takes two 32-bit source operands and a 6-bit function code, qualified by a start strobe. Multiply and divide results do not go to a general destination register. They land in a private pair of result registers: the high half holds the upper product word or the remainder, and the low half holds the lower product word or the quotient. Separate function codes move an operand into either half, or read either half back so the pipeline can write it into a general register.

Multiply completes in a single cycle: both halves update on the clock edge that samples the start strobe. Divide is an iterative restoring shift-subtract engine. It takes one quotient bit per cycle and raises a busy flag for the whole run. Signed divide works on magnitudes and then fixes the signs. Division by zero ends after the normal number of steps and leaves a defined value. While busy is high, every new operation is dropped and reads are refused, so the pipeline has to hold and retry.

Top module: `mdu_hilo`

## Requirements
- R1: After reset, busy is 0 and both the high and the low result register read as 0.
- R2: The function codes are 0x18 signed multiply, 0x19 unsigned multiply, 0x1A signed divide, 0x1B unsigned divide, 0x10 read high, 0x12 read low, 0x11 write high, 0x13 write low. An operation is accepted only when start is 1 and busy is 0.
- R3: An accepted multiply writes the upper 32 bits of the 64-bit product to the high register and the lower 32 bits to the low register on the same clock edge. Signed multiply treats the operands as two's complement and unsigned multiply treats them as unsigned. Busy is not raised.
- R4: Unsigned divide treats both operands as unsigned. It writes the quotient op_a/op_b to the low register and the remainder op_a%op_b to the high register.
- R5: Signed divide truncates the quotient toward zero, so the quotient is negative when the operand signs differ. The remainder takes the sign of the dividend. 0x80000000 divided by -1 gives quotient 0x80000000 and remainder 0.
- R6: Divide by zero, signed or unsigned, completes in the normal time. It leaves quotient 0xFFFFFFFF in the low register and the raw dividend in the high register.
- R7: Busy rises on the edge that accepts a divide and stays high for exactly 32 cycles. The results are written on the edge where busy falls.
- R8: A read function drives rd_data combinationally from the high register (0x10) or the low register (0x12). rd_valid is 1 only in that same cycle, when the read is accepted.
- R9: While busy is 1, a start of any function has no effect on either register, and a read is stalled with rd_valid at 0.
- R10: Write-high and write-low copy op_a into the named register on the accepting edge and leave the other register unchanged.
- R11: A start with any function code not listed in R2 changes neither register and never raises busy or rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation strobe, one cycle per operation |
| func | input | 6 | Function code (R2) |
| op_a | input | 32 | First source operand: dividend, multiplicand, or move-to value |
| op_b | input | 32 | Second source operand: divisor or multiplier |
| busy | output | 1 | Divide in progress |
| rd_data | output | 32 | High or low register, selected by the read function |
| rd_valid | output | 1 | The read in this cycle was accepted |

## Verification
The assertions assume that start is never X after reset and that the pipeline drops an operation that arrives while busy rather than queuing it. The bench keeps within this by driving every input on the falling edge. It polls busy until it falls before it issues the next real operation, and it issues operations during busy only on purpose, to show that they are ignored. The division identity check assumes a non-zero divisor. Divide-by-zero vectors are checked directly against their defined values.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [5:0] {
    FN_RD_HI  = 6'h10,
    FN_WR_HI  = 6'h11,
    FN_RD_LO  = 6'h12,
    FN_WR_LO  = 6'h13,
    FN_MUL_S  = 6'h18,
    FN_MUL_U  = 6'h19,
    FN_DIV_S  = 6'h1A,
    FN_DIV_U  = 6'h1B
  } mdu_fn_e;
endpackage

// File: rtl/mdu_mult.sv
module mdu_mult #(
  parameter int W = 32
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           sgn,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  function automatic logic [PW-1:0] widen(input logic [W-1:0] v, input logic s);
    return {{W{s & v[W-1]}}, v};
  endfunction

  function automatic logic [PW-1:0] full_product(input logic [W-1:0] x,
                                                 input logic [W-1:0] y,
                                                 input logic s);
    logic [PW-1:0] ex, ey;
    ex = widen(x, s);
    ey = widen(y, s);
    return ex * ey;
  endfunction

  assign prod = full_product(a, b, sgn);
endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic         sgn,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  function automatic logic [W-1:0] magnitude(input logic [W-1:0] v, input logic s);
    return (s && v[W-1]) ? (~v + 1'b1) : v;
  endfunction

  // one restoring step: returns {partial remainder, shifted quotient}
  function automatic logic [2*W-1:0] div_step(input logic [W-1:0] r,
                                              input logic [W-1:0] q,
                                              input logic [W-1:0] d);
    logic [W:0] sh, diff;
    sh   = {r, q[W-1]};
    diff = sh - {1'b0, d};
    if (!diff[W]) return {diff[W-1:0], q[W-2:0], 1'b1};
    else          return {sh[W-1:0],   q[W-2:0], 1'b0};
  endfunction

  logic [CW-1:0] cnt;
  logic [W-1:0]  part_r, work_q, mag_d, raw_a, raw_b;
  logic          neg_q, neg_r, by_zero;
  logic [2*W-1:0] nxt;
  logic [W-1:0]  step_q, step_r;

  assign busy   = (cnt != '0);
  assign done   = busy && (cnt == CW'(1));
  assign nxt    = div_step(part_r, work_q, mag_d);
  assign step_r = nxt[2*W-1:W];
  assign step_q = nxt[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      part_r  <= '0;
      work_q  <= '0;
      mag_d   <= '0;
      raw_a   <= '0;
      raw_b   <= '0;
      neg_q   <= 1'b0;
      neg_r   <= 1'b0;
      by_zero <= 1'b0;
    end else if (go && !busy) begin
      cnt     <= CW'(W);
      part_r  <= '0;
      work_q  <= magnitude(dividend, sgn);
      mag_d   <= magnitude(divisor, sgn);
      raw_a   <= dividend;
      raw_b   <= divisor;
      neg_q   <= sgn && (dividend[W-1] ^ divisor[W-1]);
      neg_r   <= sgn && dividend[W-1];
      by_zero <= (divisor == '0);
    end else if (busy) begin
      cnt    <= cnt - CW'(1);
      part_r <= step_r;
      work_q <= step_q;
    end
  end

  always_comb begin
    if (by_zero) begin
      quo = '1;
      rem = raw_a;
    end else begin
      quo = neg_q ? (~step_q + 1'b1) : step_q;
      rem = neg_r ? (~step_r + 1'b1) : step_r;
    end
  end

  // R4/R5: quotient*divisor + remainder reproduces the dividend
  assert_div_identity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && raw_b != '0) |-> (W'(quo * raw_b) + rem) == raw_a);

  // R7: busy only ends through the final step
  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

  // R7: an accepted start raises busy on the next cycle
  assert_busy_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy) |=> busy);
endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [5:0]   func,
  input  logic [31:0]  op_a,
  input  logic [31:0]  op_b,
  output logic         busy,
  output logic [31:0]  rd_data,
  output logic         rd_valid
);
  logic [W-1:0]   hi_q, lo_q;
  logic           accept, is_mul, is_div, is_rd, mul_sgn, div_sgn;
  logic [2*W-1:0] prod;
  logic           div_done;
  logic [W-1:0]   div_q, div_r;

  assign accept  = start && !busy;
  assign is_mul  = (func == FN_MUL_S) || (func == FN_MUL_U);
  assign is_div  = (func == FN_DIV_S) || (func == FN_DIV_U);
  assign is_rd   = (func == FN_RD_HI) || (func == FN_RD_LO);
  assign mul_sgn = (func == FN_MUL_S);
  assign div_sgn = (func == FN_DIV_S);

  mdu_mult #(.W(W)) u_mult (
    .a(op_a), .b(op_b), .sgn(mul_sgn), .prod(prod)
  );

  mdu_div #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(accept && is_div), .sgn(div_sgn),
    .dividend(op_a), .divisor(op_b), .busy(busy), .done(div_done),
    .quo(div_q), .rem(div_r)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (div_done) begin
      hi_q <= div_r;
      lo_q <= div_q;
    end else if (accept) begin
      if (is_mul) begin
        hi_q <= prod[2*W-1:W];
        lo_q <= prod[W-1:0];
      end else if (func == FN_WR_HI) begin
        hi_q <= op_a;
      end else if (func == FN_WR_LO) begin
        lo_q <= op_a;
      end
    end
  end

  assign rd_data  = (func == FN_RD_HI) ? hi_q : lo_q;
  assign rd_valid = accept && is_rd;

  // R3: low word of any accepted multiply equals the truncated operand product
  assert_mul_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_mul) |=> lo_q == W'($past(op_a) * $past(op_b)));

  // R9: registers frozen during a divide until its final step
  assert_hold_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !div_done) |=> ($stable(hi_q) && $stable(lo_q)));

  // R9: no read is granted while busy
  assert_read_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_valid);

  // R10: write-high leaves low untouched
  assert_write_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && func == FN_WR_HI) |=> (hi_q == $past(op_a) && $stable(lo_q)));
endmodule

// File: tb/sim_mdu_hilo.sv
module sim_mdu_hilo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  func = 6'h0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        busy, rd_valid;
  logic [31:0] rd_data;
  int          n_chk = 0, n_bad = 0;
  int          cyc = 0;

  always #2 clk = ~clk;

  mdu_hilo u0 (.clk(clk), .rst_n(rst_n), .start(start), .func(func),
               .op_a(op_a), .op_b(op_b), .busy(busy), .rd_data(rd_data),
               .rd_valid(rd_valid));

  // {func, op_a, op_b, expected high, expected low}
  localparam int NV = 14;
  localparam logic [133:0] VEC [NV] = '{
    {6'h19, 32'h0001_0000, 32'h0001_0000, 32'h0000_0001, 32'h0000_0000},
    {6'h18, 32'hFFFF_FFFF, 32'h0000_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {6'h19, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h0000_0001},
    {6'h18, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0001},
    {6'h18, 32'h8000_0000, 32'h8000_0000, 32'h4000_0000, 32'h0000_0000},
    {6'h1B, 32'd100,       32'd7,         32'd2,         32'd14},
    {6'h1B, 32'hFFFF_FFFF, 32'h0000_0010, 32'h0000_000F, 32'h0FFF_FFFF},
    {6'h1A, 32'hFFFF_FFF9, 32'd2,         32'hFFFF_FFFF, 32'hFFFF_FFFD},
    {6'h1A, 32'd7,         32'hFFFF_FFFE, 32'd1,         32'hFFFF_FFFD},
    {6'h1A, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'd3},
    {6'h1A, 32'h8000_0000, 32'hFFFF_FFFF, 32'd0,         32'h8000_0000},
    {6'h1B, 32'd5,         32'd0,         32'd5,         32'hFFFF_FFFF},
    {6'h1A, 32'hFFFF_FFF9, 32'd0,         32'hFFFF_FFF9, 32'hFFFF_FFFF},
    {6'h1B, 32'd3,         32'd9,         32'd3,         32'd0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    start = 1'b1; func = f; op_a = a; op_b = b;
    @(negedge clk);
    start = 1'b0; func = 6'h0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic read_reg(input logic [5:0] f, output logic [31:0] d, output logic v);
    @(negedge clk);
    start = 1'b1; func = f;
    #1;
    d = rd_data; v = rd_valid;
    @(negedge clk);
    start = 1'b0; func = 6'h0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d;
    logic v;
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", {31'b0, busy}, 32'd0);
    read_reg(6'h10, d, v); check("R1 hi", d, 32'd0);
    read_reg(6'h12, d, v); check("R1 lo", d, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2..R6 vector table
    for (int i = 0; i < NV; i++) begin
      logic [133:0] e;
      e = VEC[i];
      issue(e[133:128], e[127:96], e[95:64]);
      wait_idle();
      read_reg(6'h10, d, v); check($sformatf("R2 vec%0d hi", i), d, e[63:32]);
      read_reg(6'h12, d, v); check($sformatf("R2 vec%0d lo", i), d, e[31:0]);
    end

    // R3: multiply does not raise busy
    issue(6'h19, 32'd3, 32'd4);
    check("R3 no busy", {31'b0, busy}, 32'd0);

    // R5 signed remainder sign; R6 zero divisor signed
    issue(6'h1A, 32'hFFFF_FFEC, 32'd6); wait_idle();
    read_reg(6'h10, d, v); check("R5 rem", d, 32'hFFFF_FFFE);
    read_reg(6'h12, d, v); check("R5 quo", d, 32'hFFFF_FFFD);
    issue(6'h1A, 32'd9, 32'd0); wait_idle();
    read_reg(6'h12, d, v); check("R6 quo", d, 32'hFFFF_FFFF);
    read_reg(6'h10, d, v); check("R6 rem", d, 32'd9);

    // R7 busy length, R9 stall and ignore
    issue(6'h1B, 32'd50, 32'd8);
    n = 0;
    @(negedge clk);
    start = 1'b1; func = 6'h10; #1;
    check("R9 read stalled", {31'b0, rd_valid}, 32'd0);
    func = 6'h11; op_a = 32'hDEAD_BEEF;
    @(negedge clk);
    func = 6'h19;
    @(negedge clk);
    start = 1'b0; func = 6'h0;
    n = 3;
    while (busy) begin n++; @(negedge clk); end
    check("R7 busy cycles", n, 32'd32);
    read_reg(6'h10, d, v); check("R9 hi after ignored", d, 32'd2);
    read_reg(6'h12, d, v); check("R9 lo after ignored", d, 32'd6);

    // R8 read same cycle
    read_reg(6'h12, d, v);
    check("R8 valid", {31'b0, v}, 32'd1);

    // R10 move-to
    issue(6'h11, 32'hA5A5_0001, 32'd0);
    read_reg(6'h12, d, v); check("R10 lo kept", d, 32'd6);
    issue(6'h13, 32'h0000_5A5A, 32'd0);
    read_reg(6'h10, d, v); check("R10 hi", d, 32'hA5A5_0001);
    read_reg(6'h12, d, v); check("R10 lo", d, 32'h0000_5A5A);

    // R11 unknown code
    @(negedge clk);
    start = 1'b1; func = 6'h20; op_a = 32'h1234_5678; #1;
    check("R11 no valid", {31'b0, rd_valid}, 32'd0);
    @(negedge clk);
    start = 1'b0;
    check("R11 no busy", {31'b0, busy}, 32'd0);
    read_reg(6'h10, d, v); check("R11 hi", d, 32'hA5A5_0001);
    read_reg(6'h12, d, v); check("R11 lo", d, 32'h0000_5A5A);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule